// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block runs once after reset, when software or a reset controller asks for it, on a set of open-drain I2C buses. A slave can be left holding SDA low when the host is reset in the middle of a read. The block visits each bus in turn and releases both lines. It then samples SDA. A bus whose SDA already reads high is handed back straight away, with no clocking.

For a bus whose SDA is low, the block keeps SCL released for a long settle time. It then clocks SCL until the slave has shifted out the rest of its byte. It presents a NAK so the slave stops driving, and it ends with a STOP condition. SDA is then sampled again. If it is still low, that bus is marked as failed in a mask. Every bus that is visited gets a one-cycle hand-back strobe before the next bus is examined.

All delays are whole time units. A prescaler divides the system clock into these units, so one parameter scales every delay. Each line is driven open-drain: the block asserts a pull-low enable and reads the line through a two-flop synchronizer.

Top module: `i2c_bus_rescue`

## Requirements
- R1: After reset every pull-low output is 0, `done` is 0, `bus_done` is 0 and `fail_mask` is 0.
- R2: After `start`, buses are visited one at a time in ascending order. Bus k (k = 1..NUM_BUSES) uses bit k-1 of `scl_pull`, `sda_pull`, `sda_in` and `bus_done`. Only the bus being visited may have a pull-low asserted.
- R3: Each visit begins with a probe of one unit with both lines released. If the synchronized SDA is high at the end of the probe, the bus gets no SCL pulse, and its hand-back strobe follows in the next cycle.
- R4: If SDA is low at the end of the probe, SCL stays released for SETTLE_UNITS units before the first pulse.
- R5: Next come PULSES (default 9) clock pulses. Each pulse has SCL released for HALF_UNITS units and then pulled low for HALF_UNITS units. One unit is CLKS_PER_UNIT clock cycles, so every delay of D units lasts exactly D*CLKS_PER_UNIT cycles.
- R6: After the last pulse, SDA stays released (NAK) and SCL stays low for one more unit. SCL is then released for HALF_UNITS and pulled low for HALF_UNITS.
- R7: The STOP is made in three steps: SDA pulled with SCL low for HALF_UNITS, then SCL released with SDA still pulled for HALF_UNITS, then SDA released with SCL high for HALF_UNITS. SDA is never newly pulled while SCL stays released.
- R8: After the STOP, both lines are released for one unit and SDA is sampled. If it reads low, bit k of `fail_mask` is set for bus k. Bit 0 is always 0.
- R9: Each visited bus, whether skipped, recovered or failed, gets exactly one single-cycle `bus_done` pulse, in the cycle after its last timed step and before the next probe.
- R10: The cycle after the last hand-back, `done` rises. `done` and `fail_mask` then hold until the next accepted `start`. A `start` while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a recovery pass when idle |
| sda_in | input | NUM_BUSES | Sampled SDA level per bus (asynchronous) |
| scl_pull | output | NUM_BUSES | Pull SCL low when 1, release when 0 |
| sda_pull | output | NUM_BUSES | Pull SDA low when 1, release when 0 |
| bus_done | output | NUM_BUSES | One-cycle hand-back strobe per bus |
| done | output | 1 | Pass finished; held until next start |
| fail_mask | output | NUM_BUSES+1 | Bit k set when bus k stayed low; bit 0 unused |

## Verification
The hardest case to reach is the boundary between a slave that lets go during the NAK clock and one that never lets go. The outcome depends on how many SCL falling edges the sequence makes before the final sample. The bench models each slave as holding SDA low until it has counted a set number of falling edges on its SCL line. Counts of 10 and 11 sit exactly on either side of the ten falling edges (nine pulses plus the NAK clock), so one bus recovers and the next fails in the same pass. Every cycle of the waveform is compared against a queue built from the requirement timings. This queue also shows that a `start` issued in the middle of a pass is ignored.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PROBE,
        PH_SETTLE,
        PH_CLK_HI,
        PH_CLK_LO,
        PH_NAK_LEAD,
        PH_NAK_HI,
        PH_NAK_LO,
        PH_STOP_LO,
        PH_STOP_SCL,
        PH_STOP_REL,
        PH_VERIFY,
        PH_HANDBACK
    } phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    localparam int SAMPLE_UNITS = 1;
    localparam int NAK_LEAD_UNITS = 1;

    function automatic line_drive_t drive_of(phase_e ph);
        line_drive_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        case (ph)
            PH_CLK_LO, PH_NAK_LEAD, PH_NAK_LO: d.scl_low = 1'b1;
            PH_STOP_LO: begin
                d.scl_low = 1'b1;
                d.sda_low = 1'b1;
            end
            PH_STOP_SCL: d.sda_low = 1'b1;
            default: d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic is_timed(phase_e ph);
        return !(ph == PH_IDLE || ph == PH_HANDBACK);
    endfunction

endpackage

// File: rtl/rescue_unit_timer.sv
module rescue_unit_timer #(
    parameter int CLKS_PER_UNIT = 100,
    parameter int UNIT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [UNIT_W-1:0] load_units,
    output logic              expire
);
    localparam int PRE_W = (CLKS_PER_UNIT > 1) ? $clog2(CLKS_PER_UNIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_UNIT - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [UNIT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            pre_q  <= '0;
            left_q <= load_units;
        end else if (left_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q  <= '0;
                left_q <= left_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expire = (left_q == UNIT_W'(1)) && (pre_q == PRE_LAST);
endmodule

// File: rtl/rescue_sda_sync.sv
module rescue_sda_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_in,
    output logic [WIDTH-1:0] line_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= 1'b1;
                stable_q <= 1'b1;
            end else begin
                meta_q   <= line_in[g];
                stable_q <= meta_q;
            end
        end
        assign line_out[g] = stable_q;
    end
endmodule

// File: rtl/rescue_sequencer.sv
module rescue_sequencer
    import i2c_rescue_pkg::*;
#(
    parameter int NUM_BUSES = 3,
    parameter int PULSES = 9,
    parameter int SETTLE_UNITS = 10000,
    parameter int HALF_UNITS = 5,
    parameter int UNIT_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NUM_BUSES-1:0] sda_s,
    input  logic                 expire,
    output logic                 tmr_load,
    output logic [UNIT_W-1:0]    tmr_units,
    output logic [NUM_BUSES-1:0] scl_pull,
    output logic [NUM_BUSES-1:0] sda_pull,
    output logic [NUM_BUSES-1:0] bus_done,
    output logic                 done,
    output logic [NUM_BUSES:0]   fail_mask
);
    localparam int IDX_W = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1;
    localparam int PC_W = $clog2(PULSES + 1);
    localparam logic [IDX_W-1:0] LAST_BUS = IDX_W'(NUM_BUSES - 1);
    localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(PULSES - 1);

    phase_e           ph_q, ph_n;
    logic [IDX_W-1:0] bus_q, bus_n;
    logic [PC_W-1:0]  pcnt_q, pcnt_n;
    logic             done_q, done_n;
    logic [NUM_BUSES:0] fail_q, fail_n;
    logic [NUM_BUSES-1:0] bus_sel;
    line_drive_t      drv;

    assign bus_sel = NUM_BUSES'(1) << bus_q;

    always_comb begin
        ph_n     = ph_q;
        bus_n    = bus_q;
        pcnt_n   = pcnt_q;
        done_n   = done_q;
        fail_n   = fail_q;
        bus_done = '0;
        case (ph_q)
            PH_IDLE: if (start) begin
                ph_n   = PH_PROBE;
                bus_n  = '0;
                done_n = 1'b0;
                fail_n = '0;
            end
            PH_PROBE:    if (expire) ph_n = sda_s[bus_q] ? PH_HANDBACK : PH_SETTLE;
            PH_SETTLE:   if (expire) begin
                ph_n   = PH_CLK_HI;
                pcnt_n = '0;
            end
            PH_CLK_HI:   if (expire) ph_n = PH_CLK_LO;
            PH_CLK_LO:   if (expire) begin
                if (pcnt_q == LAST_PULSE) begin
                    ph_n = PH_NAK_LEAD;
                end else begin
                    pcnt_n = pcnt_q + 1'b1;
                    ph_n   = PH_CLK_HI;
                end
            end
            PH_NAK_LEAD: if (expire) ph_n = PH_NAK_HI;
            PH_NAK_HI:   if (expire) ph_n = PH_NAK_LO;
            PH_NAK_LO:   if (expire) ph_n = PH_STOP_LO;
            PH_STOP_LO:  if (expire) ph_n = PH_STOP_SCL;
            PH_STOP_SCL: if (expire) ph_n = PH_STOP_REL;
            PH_STOP_REL: if (expire) ph_n = PH_VERIFY;
            PH_VERIFY:   if (expire) begin
                if (!sda_s[bus_q]) fail_n = fail_q | ((NUM_BUSES + 1)'(2) << bus_q);
                ph_n = PH_HANDBACK;
            end
            PH_HANDBACK: begin
                bus_done = bus_sel;
                if (bus_q == LAST_BUS) begin
                    ph_n   = PH_IDLE;
                    done_n = 1'b1;
                end else begin
                    bus_n = IDX_W'(bus_q + 1'b1);
                    ph_n  = PH_PROBE;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_comb begin
        tmr_load  = (ph_n != ph_q) && is_timed(ph_n);
        tmr_units = UNIT_W'(HALF_UNITS);
        case (ph_n)
            PH_PROBE, PH_VERIFY: tmr_units = UNIT_W'(SAMPLE_UNITS);
            PH_SETTLE:           tmr_units = UNIT_W'(SETTLE_UNITS);
            PH_NAK_LEAD:         tmr_units = UNIT_W'(NAK_LEAD_UNITS);
            default:             tmr_units = UNIT_W'(HALF_UNITS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            bus_q  <= '0;
            pcnt_q <= '0;
            done_q <= 1'b0;
            fail_q <= '0;
        end else begin
            ph_q   <= ph_n;
            bus_q  <= bus_n;
            pcnt_q <= pcnt_n;
            done_q <= done_n;
            fail_q <= fail_n;
        end
    end

    assign drv       = drive_of(ph_q);
    assign scl_pull  = drv.scl_low ? bus_sel : '0;
    assign sda_pull  = drv.sda_low ? bus_sel : '0;
    assign done      = done_q;
    assign fail_mask = fail_q;
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue #(
    parameter int NUM_BUSES = 3,
    parameter int CLKS_PER_UNIT = 100,
    parameter int PULSES = 9,
    parameter int SETTLE_UNITS = 10000,
    parameter int HALF_UNITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NUM_BUSES-1:0] sda_in,
    output logic [NUM_BUSES-1:0] scl_pull,
    output logic [NUM_BUSES-1:0] sda_pull,
    output logic [NUM_BUSES-1:0] bus_done,
    output logic                 done,
    output logic [NUM_BUSES:0]   fail_mask
);
    localparam int MAX_UNITS = (SETTLE_UNITS > HALF_UNITS) ? SETTLE_UNITS : HALF_UNITS;
    localparam int UNIT_W = $clog2(MAX_UNITS + 2);

    logic [NUM_BUSES-1:0] sda_s;
    logic                 tmr_load;
    logic [UNIT_W-1:0]    tmr_units;
    logic                 tmr_expire;

    rescue_sda_sync #(.WIDTH(NUM_BUSES)) u_sync (
        .clk(clk), .rst(rst), .line_in(sda_in), .line_out(sda_s)
    );

    rescue_unit_timer #(.CLKS_PER_UNIT(CLKS_PER_UNIT), .UNIT_W(UNIT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_units(tmr_units), .expire(tmr_expire)
    );

    rescue_sequencer #(
        .NUM_BUSES(NUM_BUSES), .PULSES(PULSES), .SETTLE_UNITS(SETTLE_UNITS),
        .HALF_UNITS(HALF_UNITS), .UNIT_W(UNIT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .sda_s(sda_s), .expire(tmr_expire),
        .tmr_load(tmr_load), .tmr_units(tmr_units), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .bus_done(bus_done), .done(done), .fail_mask(fail_mask)
    );
endmodule

// File: rtl/i2c_bus_rescue_chk.sv
module i2c_bus_rescue_chk #(
    parameter int NUM_BUSES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [NUM_BUSES-1:0] scl_pull,
    input logic [NUM_BUSES-1:0] sda_pull,
    input logic [NUM_BUSES-1:0] bus_done,
    input logic                 done,
    input logic [NUM_BUSES:0]   fail_mask
);
    a_r2_one_bus_driven: assert property (@(posedge clk) disable iff (rst)
        $onehot0(scl_pull | sda_pull));

    a_r9_single_handback: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_done));

    a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail_mask)));

    a_r9_no_drive_at_handback: assert property (@(posedge clk) disable iff (rst)
        (bus_done != '0) |-> (scl_pull == '0 && sda_pull == '0));

    for (genvar g = 0; g < NUM_BUSES; g++) begin : g_line
        a_r7_no_false_start: assert property (@(posedge clk) disable iff (rst)
            (!scl_pull[g] && !$past(scl_pull[g])) |-> !(sda_pull[g] && !$past(sda_pull[g])));
    end
endmodule

bind i2c_bus_rescue i2c_bus_rescue_chk #(.NUM_BUSES(NUM_BUSES)) u_chk (
    .clk(clk), .rst(rst), .start(start), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .bus_done(bus_done), .done(done), .fail_mask(fail_mask)
);

// File: tb/test_i2c_bus_rescue.sv
module test_i2c_bus_rescue;
    localparam int NB = 3;
    localparam int U = 2;
    localparam int PULSES = 9;
    localparam int SETTLE = 20;
    localparam int HALF = 2;

    typedef struct {
        logic [NB-1:0] scl;
        logic [NB-1:0] sda;
        logic [NB-1:0] bd;
        int            req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NB-1:0] sda_in;
    logic [NB-1:0] scl_pull, sda_pull, bus_done;
    logic done;
    logic [NB:0] fail_mask;

    int compared = 0;
    int mismatched = 0;
    int need [NB];
    int falls [NB];
    logic clr_falls = 1'b1;
    logic [NB-1:0] scl_prev;
    exp_t q[$];

    always #4 clk = ~clk;

    i2c_bus_rescue #(
        .NUM_BUSES(NB), .CLKS_PER_UNIT(U), .PULSES(PULSES),
        .SETTLE_UNITS(SETTLE), .HALF_UNITS(HALF)
    ) i_i2c_bus_rescue (
        .clk(clk), .rst(rst), .start(start), .sda_in(sda_in), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .bus_done(bus_done), .done(done), .fail_mask(fail_mask)
    );

    // Slave model: holds SDA low until it has seen need[b] SCL falling edges.
    always @(posedge clk) begin
        scl_prev <= scl_pull;
        for (int b = 0; b < NB; b++) begin
            if (clr_falls) falls[b] <= 0;
            else if (scl_pull[b] && !scl_prev[b]) falls[b] <= falls[b] + 1;
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++)
            sda_in[b] = !(falls[b] < need[b]) && !sda_pull[b];
    end

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL R%0d %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic push(input int cycles, input int bus, input bit scl, input bit sda, input bit bd, input int req);
        exp_t e;
        e.scl = scl ? NB'(1) << bus : '0;
        e.sda = sda ? NB'(1) << bus : '0;
        e.bd  = bd ? NB'(1) << bus : '0;
        e.req = req;
        for (int i = 0; i < cycles; i++) q.push_back(e);
    endtask

    // Builds the expected waveform of one pass and returns the expected mask.
    task automatic build(output logic [NB:0] mask);
        mask = '0;
        for (int b = 0; b < NB; b++) begin
            push(U, b, 0, 0, 0, 3);                       // R3 probe
            if (need[b] > 0) begin
                push(SETTLE * U, b, 0, 0, 0, 4);          // R4 settle
                for (int p = 0; p < PULSES; p++) begin
                    push(HALF * U, b, 0, 0, 0, 5);        // R5 high
                    push(HALF * U, b, 1, 0, 0, 5);        // R5 low
                end
                push(U, b, 1, 0, 0, 6);                   // R6 NAK lead
                push(HALF * U, b, 0, 0, 0, 6);
                push(HALF * U, b, 1, 0, 0, 6);
                push(HALF * U, b, 1, 1, 0, 7);            // R7 stop steps
                push(HALF * U, b, 0, 1, 0, 7);
                push(HALF * U, b, 0, 0, 0, 7);
                push(U, b, 0, 0, 0, 8);                   // R8 verify
                if (need[b] > PULSES + 1) mask[b+1] = 1'b1;
            end
            push(1, b, 0, 0, 1, 9);                       // R9 hand-back
        end
    endtask

    task automatic run_pass(input int n0, input int n1, input int n2, input int busy_at);
        logic [NB:0] mask;
        int cyc;
        need[0] = n0; need[1] = n1; need[2] = n2;
        clr_falls = 1'b1;
        @(negedge clk);
        clr_falls = 1'b0;
        build(mask);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("scl_pull", e.req, 32'(scl_pull), 32'(e.scl));  // R2 only current bus
            check("sda_pull", e.req, 32'(sda_pull), 32'(e.sda));
            check("bus_done", e.req, 32'(bus_done), 32'(e.bd));
            check("done low while busy", 10, 32'(done), 32'd0);
            start = (cyc == busy_at);                              // R10 ignored start
            cyc++;
            @(negedge clk);
            start = 1'b0;
        end
        check("done", 10, 32'(done), 32'd1);
        check("fail_mask", 8, 32'(fail_mask), 32'(mask));
        repeat (5) @(negedge clk);
        check("done held", 10, 32'(done), 32'd1);
        check("mask held", 10, 32'(fail_mask), 32'(mask));
        check("lines idle", 10, 32'({scl_pull, sda_pull}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) need[b] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("scl after reset", 1, 32'(scl_pull), 32'd0);
        check("sda after reset", 1, 32'(sda_pull), 32'd0);
        check("done after reset", 1, 32'(done), 32'd0);
        check("bus_done after reset", 1, 32'(bus_done), 32'd0);
        check("mask after reset", 1, 32'(fail_mask), 32'd0);
        // R3 all buses free: probes and hand-backs only
        run_pass(0, 0, 0, -1);
        // R4 R5 R6 R7 bus 1 stuck, start pulsed mid-pass
        run_pass(3, 0, 0, 60);
        // R8 boundary: 10 falls recovers, 11 fails
        run_pass(0, 10, 11, -1);
        // R8 all fail, then a new pass clears the result
        run_pass(1000, 1000, 1000, -1);
        run_pass(0, 0, 0, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule